// File: doc/BRIEF.md
# Cache-Way Scratchpad Partition Controller

This block sits beside the way-0 tag array of a small set-associative L1 cache. It turns the upper sets of way 0 into a directly addressed scratchpad RAM. A 2-bit size field reserves none, half, three quarters or all of way 0, which is 2, 3 or 4 KB with the default 4 KB way. A 2-bit region field places the scratchpad's 4 KB window in upper memory. The block owns the way-0 tags and valid bits. For every lookup it reports, in the same cycle, whether the address hits the scratchpad, whether way 0 holds a valid matching line, and whether the line is reserved. Reserved lines always read as valid. Their tags cannot be rewritten or refilled. A flush never clears them, and the replacement and write-back logic is told they may not be evicted.

Software first loads the way-0 tags through the test write port while the size field is zero. It then programs the size and region, which locks the reserved lines, and only after that enables the cache. The configuration is captured by a three-state controller. In `ST_OFF` the cache is disabled and no scratchpad is reserved. In `ST_RESV` the cache is disabled and lines are reserved. In `ST_RUN` the cache is enabled. While the controller is in `ST_OFF` or `ST_RESV`, the size and region fields are copied into active registers on every clock. Its transitions are:

- Raising `cache_en` moves `ST_OFF` or `ST_RESV` to `ST_RUN`.
- With the cache still disabled, a nonzero size moves `ST_OFF` to `ST_RESV`, and a size of zero moves `ST_RESV` back to `ST_OFF`.
- Dropping `cache_en` moves `ST_RUN` to `ST_RESV` if the size field is nonzero, and to `ST_OFF` otherwise.

In `ST_RUN` the active configuration is frozen.

Top module: `sp_partition_ctl`

## Requirements
- R1: Size encoding: 2'b00 reserves nothing, 2'b01 reserves the top SETS/2 sets of way 0, 2'b10 the top 3*SETS/4 sets, and 2'b11 all SETS sets. A set index s is reserved when s >= SETS minus the reserved count.
- R2: `w0_free_bytes` equals WAY_BYTES minus the reserved bytes: 4096, 2048, 1024 or 0 by default. It is 4096 after reset.
- R3: The scratchpad window is the 4 KB page whose page number is {region, all ones in the lower bits}. For region 2'b10 that page is 0xBFFFF. `lk_sp_hit` is high in the same cycle as `lk_addr` when the address lies in that page and its set (address bits [11:4]) is reserved.
- R4: A reserved line reads `lk_w0_valid` = 1 whether or not it was ever loaded or flushed. An unreserved line reads the valid bit that was written to it.
- R5: A one-cycle `flush` clears the valid bit of every unreserved way-0 line. Reserved lines keep their valid state and their tags.
- R6: `vq_w0_ok` is 0 when `vq_set` is a reserved set, which forbids its eviction and write-back. It is 1 for every other set.
- R7: While lines are reserved, test-port tag writes and fills that target a reserved set are ignored. Writes to unreserved sets take effect one clock later.
- R8: While the cache is enabled, changes to size or region are ignored. `cfg_err` is high while the inputs differ from the frozen configuration.
- R9: A size or region written while the cache is disabled becomes active one clock later. After `cache_en` falls, a pending size takes effect on the second clock edge.
- R10: After reset, no line is valid, nothing is reserved and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Scratchpad size select |
| cfg_region | input | 2 | Upper-memory region select |
| cache_en | input | 1 | Normal cache operation enabled |
| tw_en | input | 1 | Test-port tag write strobe |
| tw_set | input | 8 | Test-port set index |
| tw_tag | input | 20 | Test-port tag value |
| tw_valid | input | 1 | Test-port valid value |
| fill_en | input | 1 | Line fill strobe |
| fill_set | input | 8 | Fill set index |
| fill_tag | input | 20 | Fill tag |
| flush | input | 1 | Invalidate unreserved way-0 lines |
| lk_addr | input | 32 | Lookup byte address |
| lk_sp_hit | output | 1 | Lookup hits the scratchpad |
| lk_w0_hit | output | 1 | Way-0 valid tag match |
| lk_w0_valid | output | 1 | Effective way-0 valid bit at lookup set |
| vq_set | input | 8 | Victim/write-back query set |
| vq_w0_ok | output | 1 | Way-0 line at query set may be evicted |
| w0_free_bytes | output | 13 | Way-0 bytes left for normal caching |
| cfg_err | output | 1 | Illegal size or region change while enabled |

## Verification
The hardest situation to reach is a reserved line whose tag was loaded before the lock and which then survives a later overwrite attempt, a refill and a flush. That line must still hit afterwards, and an unreserved neighbour must still be lost to the flush. The stimulus first loads a tag with the size at zero and then raises the size. It next fires a test write and a fill at the same set and then a flush, and it looks up that set and an unreserved one after each step. A second hard case is a reconfiguration attempt while the cache is running, followed by disabling the cache. The bench first checks that nothing moved and then waits out the two-edge delay before the new size takes effect.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RESV = 2'd1,
        ST_RUN  = 2'd2
    } sp_state_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_3Q   = 2'd2,
        SZ_FULL = 2'd3
    } sp_size_e;

    // Reserved share of way 0 in quarters
    function automatic logic [2:0] size_quarters(input logic [1:0] sz);
        logic [2:0] q;
        unique case (sz)
            SZ_HALF: q = 3'd2;
            SZ_3Q:   q = 3'd3;
            SZ_FULL: q = 3'd4;
            default: q = 3'd0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/sp_cfg_fsm.sv
module sp_cfg_fsm
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_size,
    input  logic [1:0] cfg_region,
    input  logic       cache_en,
    output logic [1:0] act_size,
    output logic [1:0] act_region,
    output logic       cfg_err,
    output sp_state_e  state
);

    sp_state_e  state_q, state_d;
    logic [1:0] size_q, region_q;
    logic       cfg_open;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cache_en)              state_d = ST_RUN;
                else if (cfg_size != 2'd0) state_d = ST_RESV;
            end
            ST_RESV: begin
                if (cache_en)              state_d = ST_RUN;
                else if (cfg_size == 2'd0) state_d = ST_OFF;
            end
            ST_RUN: begin
                if (!cache_en)
                    state_d = (cfg_size != 2'd0) ? ST_RESV : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        cfg_open = (state_q != ST_RUN);
        cfg_err  = (state_q == ST_RUN) &&
                   ((cfg_size != size_q) || (cfg_region != region_q));
    end

    // Active configuration follows the inputs only while the cache is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q   <= 2'd0;
            region_q <= 2'd0;
        end else if (cfg_open) begin
            size_q   <= cfg_size;
            region_q <= cfg_region;
        end
    end

    assign act_size   = size_q;
    assign act_region = region_q;
    assign state      = state_q;

endmodule

// File: rtl/sp_decode.sv
module sp_decode
    import sp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAY_BYTES  = 4096,
    parameter int LINE_BYTES = 16,
    localparam int SETS  = WAY_BYTES / LINE_BYTES,
    localparam int SET_W = $clog2(SETS),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W,
    localparam int CNT_W = SET_W + 1,
    localparam int FB_W  = $clog2(WAY_BYTES) + 1
) (
    input  logic [1:0]        act_size,
    input  logic [1:0]        act_region,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SET_W-1:0]  vq_set,
    output logic [CNT_W-1:0]  first_res,
    output logic [SET_W-1:0]  lk_set,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_resv,
    output logic              lk_in_window,
    output logic              vq_resv,
    output logic [FB_W-1:0]   free_bytes
);

    localparam int PROD_W = CNT_W + 3;

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  res_lines;
    logic [TAG_W-1:0]  win_page;

    always_comb begin
        prod       = PROD_W'(SETS) * PROD_W'(size_quarters(act_size));
        res_lines  = prod[CNT_W+1:2];
        first_res  = CNT_W'(SETS) - res_lines;
        free_bytes = FB_W'(WAY_BYTES) - FB_W'(32'(res_lines) * LINE_BYTES);

        lk_set       = lk_addr[OFF_W +: SET_W];
        lk_tag       = lk_addr[ADDR_W-1 -: TAG_W];
        win_page     = {act_region, {(TAG_W-2){1'b1}}};
        lk_resv      = ({1'b0, lk_set} >= first_res);
        lk_in_window = (lk_tag == win_page);
        vq_resv      = ({1'b0, vq_set} >= first_res);
    end

endmodule

// File: rtl/sp_tag_store.sv
module sp_tag_store #(
    parameter int SETS  = 256,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int CNT_W = SET_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] first_res,
    input  logic             tw_en,
    input  logic [SET_W-1:0] tw_set,
    input  logic [TAG_W-1:0] tw_tag,
    input  logic             tw_valid,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             flush,
    input  logic [SET_W-1:0] lk_set,
    output logic [TAG_W-1:0] lk_tag_q,
    output logic             lk_valid_q
);

    logic [TAG_W-1:0] tag_q   [SETS];
    logic             valid_q [SETS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SETS; i++) begin
            if (!rst_n) begin
                tag_q[i]   <= '0;
                valid_q[i] <= 1'b0;
            end else if (CNT_W'(i) < first_res) begin
                // only unreserved lines can change
                if (tw_en && (tw_set == SET_W'(i))) begin
                    tag_q[i]   <= tw_tag;
                    valid_q[i] <= tw_valid;
                end else if (fill_en && (fill_set == SET_W'(i))) begin
                    tag_q[i]   <= fill_tag;
                    valid_q[i] <= 1'b1;
                end else if (flush) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    assign lk_tag_q   = tag_q[lk_set];
    assign lk_valid_q = valid_q[lk_set];

endmodule

// File: rtl/sp_partition_ctl.sv
module sp_partition_ctl
    import sp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAY_BYTES  = 4096,
    parameter int LINE_BYTES = 16,
    localparam int SETS  = WAY_BYTES / LINE_BYTES,
    localparam int SET_W = $clog2(SETS),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W,
    localparam int CNT_W = SET_W + 1,
    localparam int FB_W  = $clog2(WAY_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size,
    input  logic [1:0]        cfg_region,
    input  logic              cache_en,
    input  logic              tw_en,
    input  logic [SET_W-1:0]  tw_set,
    input  logic [TAG_W-1:0]  tw_tag,
    input  logic              tw_valid,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_sp_hit,
    output logic              lk_w0_hit,
    output logic              lk_w0_valid,
    input  logic [SET_W-1:0]  vq_set,
    output logic              vq_w0_ok,
    output logic [FB_W-1:0]   w0_free_bytes,
    output logic              cfg_err
);

    logic [1:0]       act_size, act_region;
    sp_state_e        state;
    logic [CNT_W-1:0] first_res;
    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag, lk_tag_q;
    logic             lk_resv, lk_in_window, vq_resv, lk_valid_q;

    sp_cfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_size   (cfg_size),
        .cfg_region (cfg_region),
        .cache_en   (cache_en),
        .act_size   (act_size),
        .act_region (act_region),
        .cfg_err    (cfg_err),
        .state      (state)
    );

    sp_decode #(
        .ADDR_W     (ADDR_W),
        .WAY_BYTES  (WAY_BYTES),
        .LINE_BYTES (LINE_BYTES)
    ) u_dec (
        .act_size     (act_size),
        .act_region   (act_region),
        .lk_addr      (lk_addr),
        .vq_set       (vq_set),
        .first_res    (first_res),
        .lk_set       (lk_set),
        .lk_tag       (lk_tag),
        .lk_resv      (lk_resv),
        .lk_in_window (lk_in_window),
        .vq_resv      (vq_resv),
        .free_bytes   (w0_free_bytes)
    );

    sp_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_res  (first_res),
        .tw_en      (tw_en),
        .tw_set     (tw_set),
        .tw_tag     (tw_tag),
        .tw_valid   (tw_valid),
        .fill_en    (fill_en),
        .fill_set   (fill_set),
        .fill_tag   (fill_tag),
        .flush      (flush),
        .lk_set     (lk_set),
        .lk_tag_q   (lk_tag_q),
        .lk_valid_q (lk_valid_q)
    );

    always_comb begin
        lk_w0_valid = lk_resv | lk_valid_q;
        lk_w0_hit   = lk_w0_valid && (lk_tag_q == lk_tag);
        lk_sp_hit   = lk_resv && lk_in_window;
        vq_w0_ok    = !vq_resv;
    end

endmodule

// File: rtl/sp_partition_chk.sv
module sp_partition_chk
    import sp_pkg::*;
#(
    parameter int WAY_BYTES = 4096,
    parameter int FB_W      = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cache_en,
    input logic            cfg_err,
    input logic            lk_sp_hit,
    input logic            lk_w0_valid,
    input logic            vq_w0_ok,
    input logic [FB_W-1:0] w0_free_bytes,
    input sp_state_e       state
);

    a_r4_sp_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_sp_hit |-> lk_w0_valid);

    a_r2_free_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (w0_free_bytes == FB_W'(WAY_BYTES)) || (w0_free_bytes == FB_W'(WAY_BYTES/2)) ||
        (w0_free_bytes == FB_W'(WAY_BYTES/4)) || (w0_free_bytes == '0));

    a_r6_lock_needs_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        !vq_w0_ok |-> (w0_free_bytes < FB_W'(WAY_BYTES)));

    a_r8_frozen_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && $past(state == ST_RUN)) |-> $stable(w0_free_bytes));

    a_r8_err_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cache_en));

    a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) || (state == ST_RESV) || (state == ST_RUN));

endmodule

bind sp_partition_ctl sp_partition_chk #(
    .WAY_BYTES (WAY_BYTES),
    .FB_W      (FB_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cache_en      (cache_en),
    .cfg_err       (cfg_err),
    .lk_sp_hit     (lk_sp_hit),
    .lk_w0_valid   (lk_w0_valid),
    .vq_w0_ok      (vq_w0_ok),
    .w0_free_bytes (w0_free_bytes),
    .state         (state)
);

// File: tb/tb_sp_partition_ctl.sv
`timescale 1ns/1ps
module tb_sp_partition_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_size = '0, cfg_region = '0;
    logic        cache_en = 1'b0;
    logic        tw_en = 1'b0, tw_valid = 1'b0, fill_en = 1'b0, flush = 1'b0;
    logic [7:0]  tw_set = '0, fill_set = '0, vq_set = '0;
    logic [19:0] tw_tag = '0, fill_tag = '0;
    logic [31:0] lk_addr = '0;
    logic        lk_sp_hit, lk_w0_hit, lk_w0_valid, vq_w0_ok, cfg_err;
    logic [12:0] w0_free_bytes;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    localparam logic [19:0] PG_R2 = 20'hBFFFF;
    localparam logic [19:0] PG_R3 = 20'hFFFFF;

    always #4 clk = ~clk;

    sp_partition_ctl dut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_region(cfg_region),
        .cache_en(cache_en), .tw_en(tw_en), .tw_set(tw_set), .tw_tag(tw_tag),
        .tw_valid(tw_valid), .fill_en(fill_en), .fill_set(fill_set),
        .fill_tag(fill_tag), .flush(flush), .lk_addr(lk_addr),
        .lk_sp_hit(lk_sp_hit), .lk_w0_hit(lk_w0_hit), .lk_w0_valid(lk_w0_valid),
        .vq_set(vq_set), .vq_w0_ok(vq_w0_ok), .w0_free_bytes(w0_free_bytes),
        .cfg_err(cfg_err)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] pg, input logic [7:0] s);
        lk_addr = {pg, s, 4'h0};
        #1;
    endtask

    task automatic t_reset();
        look(20'h00000, 8'd5);
        chk("R10 valid after reset", lk_w0_valid, 0);
        chk("R10 cfg_err after reset", cfg_err, 0);
        chk("R2 free bytes after reset", w0_free_bytes, 4096);
        vq_set = 8'd255; #1;
        chk("R10 nothing reserved", vq_w0_ok, 1);
    endtask

    task automatic t_sizes();
        int first [4] = '{256, 128, 64, 0};
        int free  [4] = '{4096, 2048, 1024, 0};
        for (int sz = 1; sz <= 4; sz++) begin
            int e = sz % 4;
            cfg_size = 2'(e);
            step();
            chk("R2 free bytes per size", w0_free_bytes, free[e]);
            if (first[e] > 0) begin
                vq_set = 8'(first[e] - 1); #1;
                chk("R1 R6 set below boundary evictable", vq_w0_ok, 1);
            end
            if (first[e] < 256) begin
                vq_set = 8'(first[e]); #1;
                chk("R1 R6 boundary set locked", vq_w0_ok, 0);
            end
        end
    endtask

    task automatic t_lock();
        tw_en = 1; tw_valid = 1; tw_set = 8'd200; tw_tag = PG_R2;
        step();
        tw_set = 8'd10; tw_tag = 20'h12345;
        step();
        tw_en = 0;
        cfg_size = 2'd1; cfg_region = 2'd2;
        step();
        tw_en = 1; tw_set = 8'd200; tw_tag = 20'h55555;
        step();
        tw_en = 0; fill_en = 1; fill_set = 8'd200; fill_tag = 20'h66666;
        step();
        fill_en = 0;
        look(PG_R2, 8'd200);
        chk("R7 reserved tag kept", lk_w0_hit, 1);
        look(20'h55555, 8'd200);
        chk("R7 locked write ignored", lk_w0_hit, 0);
        tw_en = 1; tw_set = 8'd10; tw_tag = 20'h54321;
        step();
        tw_en = 0;
        look(20'h54321, 8'd10);
        chk("R7 unreserved write applied", lk_w0_hit, 1);
    endtask

    task automatic t_valid();
        look(20'h00000, 8'd150);
        chk("R4 unloaded reserved line valid", lk_w0_valid, 1);
        look(20'h00000, 8'd20);
        chk("R4 unloaded free line invalid", lk_w0_valid, 0);
    endtask

    task automatic t_window();
        look(PG_R2, 8'd200);
        chk("R3 window hit", lk_sp_hit, 1);
        look(PG_R2, 8'd16);
        chk("R3 window below reserve", lk_sp_hit, 0);
        look(PG_R3, 8'd200);
        chk("R3 other region", lk_sp_hit, 0);
    endtask

    task automatic t_flush();
        fill_en = 1; fill_set = 8'd20; fill_tag = 20'h0AAAA;
        step();
        fill_en = 0;
        look(20'h0AAAA, 8'd20);
        chk("R5 fill before flush", lk_w0_hit, 1);
        flush = 1;
        step();
        flush = 0;
        look(20'h0AAAA, 8'd20);
        chk("R5 free line flushed", lk_w0_valid, 0);
        look(PG_R2, 8'd200);
        chk("R5 reserved line survives", lk_w0_hit, 1);
    endtask

    task automatic t_run();
        cache_en = 1;
        step();
        cfg_size = 2'd3; cfg_region = 2'd3;
        step();
        chk("R8 err flagged", cfg_err, 1);
        chk("R8 size change ignored", w0_free_bytes, 2048);
        look(PG_R2, 8'd200);
        chk("R8 region change ignored", lk_sp_hit, 1);
        cfg_size = 2'd1; cfg_region = 2'd2; #1;
        chk("R8 err clears on match", cfg_err, 0);
        cfg_size = 2'd3;
        cache_en = 0;
        step();
        chk("R9 not yet applied", w0_free_bytes, 2048);
        step();
        chk("R9 applied after disable", w0_free_bytes, 0);
        chk("R9 no err when disabled", cfg_err, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_sizes();
        cfg_size = 2'd0;
        step();
        t_lock();
        t_valid();
        t_window();
        t_flush();
        t_run();
        finish_run();
    end

endmodule